// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Trigger Levels

This block holds the byte queues that sit between the register interface of a UART and its serialiser. It has one queue for transmit and one for receive, each 32 bytes deep. Each queue raises its own trigger flag when its programmable threshold is crossed. For the receive queue the threshold counts stored bytes. For the transmit queue it counts free spaces. The interrupt logic uses these flags to decide when software should service the port.

A single control-word write configures the block. It selects the queue mode, can flush either queue, and picks both thresholds. With queueing switched off, each path behaves as a one-byte holding register. A separate feature-enable input gates the transmit threshold. Until that input is high, the transmit trigger uses a fixed level of 16, whatever has been written. Any stored selection takes effect as soon as the input rises, with no rewrite needed.

Each path has push and pop strobes, a fill count, full and empty flags, a trigger flag and a sticky overrun flag. Read data is registered: a pop updates the read-data output one cycle later.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both counts are 0, both paths are empty and not full, both overrun flags are 0, both read-data outputs are 0, and the block is in holding mode.
- R2: Writing the control word with bit 0 = 1 selects queue mode, with 32 entries per path. Bytes leave in the order they entered, and full is raised at a count of 32.
- R3: With control bit 0 = 0, each path holds one byte: full at a count of 1, receive trigger at 1 byte, transmit trigger when empty. A write that changes bit 0 flushes both paths.
- R4: In queue mode the receive trigger is high when count >= level. Control bits 7:6 give the level: 00 selects 8, 01 selects 16, 10 selects 24, 11 selects 28.
- R5: In queue mode with the feature-enable input low, the transmit trigger is high when (32 - count) >= 16, whatever control bits 5:4 hold.
- R6: With the feature-enable input high, control bits 5:4 give the transmit level: 00 selects 16, 01 selects 8, 10 selects 24, 11 selects 30. A selection stored while the input was low applies as soon as the input rises.
- R7: Control bit 1 flushes the receive path and clears its overrun flag. Control bit 2 does the same for the transmit path. The flush acts only on the write cycle and leaves the other path untouched.
- R8: A push into a full path with no pop in the same cycle is dropped. It sets that path's overrun flag, which stays set until the path is flushed.
- R9: A pop from an empty path leaves the count at 0 and the read data unchanged.
- R10: A pop from a non-empty path presents the oldest byte on read data and lowers the count by one, both visible after the clock edge.
- R11: A push and a pop together on a full path both take effect, and the count stays at full. Together on an empty path, the push is taken, the pop is ignored and the count becomes 1.
- R12: A flush in the same cycle as a push on that path wins: the count is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word: bit0 mode, bit1 rx flush, bit2 tx flush, 5:4 tx level, 7:6 rx level |
| xfeat_en | input | 1 | Feature enable gating the transmit level selection |
| tx_push | input | 1 | Push a byte into the transmit path |
| tx_pdata | input | 8 | Byte to push into the transmit path |
| tx_pop | input | 1 | Pop a byte from the transmit path (serialiser side) |
| tx_rdata | output | 8 | Last byte popped from the transmit path |
| tx_count | output | 6 | Transmit fill count |
| tx_full | output | 1 | Transmit path full |
| tx_empty | output | 1 | Transmit path empty |
| tx_trig | output | 1 | Transmit free-space trigger reached |
| tx_ovr | output | 1 | Sticky transmit overrun |
| rx_push | input | 1 | Push a byte into the receive path (serialiser side) |
| rx_pdata | input | 8 | Byte to push into the receive path |
| rx_pop | input | 1 | Pop a byte from the receive path |
| rx_rdata | output | 8 | Last byte popped from the receive path |
| rx_count | output | 6 | Receive fill count |
| rx_full | output | 1 | Receive path full |
| rx_empty | output | 1 | Receive path empty |
| rx_trig | output | 1 | Receive fill trigger reached |
| rx_ovr | output | 1 | Sticky receive overrun |

## Verification
The collision that matters is a push and a pop on the same path in one cycle. It is hardest at the two boundaries: a full path, where the push must be accepted because the pop frees a slot, and an empty path, where the pop must be ignored while the push lands. The bench fills the transmit queue to 32 and then strikes both strobes together. It also strikes both on an empty receive queue. It checks that the count stays at 32 (or becomes 1) with no overrun, and the scoreboard confirms that the byte popped is the oldest one. A flush landing on the same cycle as a push is provoked the same way, and the count is judged to be 0.

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
  parameter int DEPTH = 32,
  parameter int W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          xfeat_en,
  input  logic          tx_push,
  input  logic [W-1:0]  tx_pdata,
  input  logic          tx_pop,
  output logic [W-1:0]  tx_rdata,
  output logic [CW-1:0] tx_count,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          tx_trig,
  output logic          tx_ovr,
  input  logic          rx_push,
  input  logic [W-1:0]  rx_pdata,
  input  logic          rx_pop,
  output logic [W-1:0]  rx_rdata,
  output logic [CW-1:0] rx_count,
  output logic          rx_full,
  output logic          rx_empty,
  output logic          rx_trig,
  output logic          rx_ovr
);

  logic       fifo_on;
  logic [1:0] rx_sel, tx_sel;
  logic       unused_bits;

  assign unused_bits = cfg_wdata[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_on <= 1'b0;
      rx_sel  <= 2'b00;
      tx_sel  <= 2'b00;
    end else if (cfg_we) begin
      fifo_on <= cfg_wdata[0];
      tx_sel  <= cfg_wdata[5:4];
      rx_sel  <= cfg_wdata[7:6];
    end
  end

  logic          flip;
  logic [CW-1:0] cap, tx_lvl, rx_lvl;

  assign flip = cfg_we && (cfg_wdata[0] != fifo_on);
  assign cap  = fifo_on ? CW'(DEPTH) : CW'(1);

  always_comb begin
    if (!fifo_on)       tx_lvl = CW'(1);
    else if (!xfeat_en) tx_lvl = CW'(DEPTH / 2);
    else begin
      case (tx_sel)
        2'b00:   tx_lvl = CW'(DEPTH / 2);
        2'b01:   tx_lvl = CW'(DEPTH / 4);
        2'b10:   tx_lvl = CW'(3 * DEPTH / 4);
        default: tx_lvl = CW'(DEPTH - 2);
      endcase
    end
  end

  always_comb begin
    if (!fifo_on) rx_lvl = CW'(1);
    else begin
      case (rx_sel)
        2'b00:   rx_lvl = CW'(DEPTH / 4);
        2'b01:   rx_lvl = CW'(DEPTH / 2);
        2'b10:   rx_lvl = CW'(3 * DEPTH / 4);
        default: rx_lvl = CW'(DEPTH - 4);
      endcase
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic          push, pop, clr, do_push, do_pop, ovr;
    logic [W-1:0]  din, dout;
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign push    = (p == 0) ? tx_push  : rx_push;
    assign pop     = (p == 0) ? tx_pop   : rx_pop;
    assign din     = (p == 0) ? tx_pdata : rx_pdata;
    assign clr     = cfg_we && (((p == 0) ? cfg_wdata[2] : cfg_wdata[1]) || flip);
    assign do_pop  = pop && (cnt != '0);
    assign do_push = push && ((cnt < cap) || do_pop);

    always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp   <= '0;
        rp   <= '0;
        cnt  <= '0;
        ovr  <= 1'b0;
        dout <= '0;
      end else if (clr) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
        ovr <= 1'b0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop) begin
          dout <= mem[rp];
          rp   <= rp + 1'b1;
        end
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
        if (push && !do_push) ovr <= 1'b1;
      end
    end
  end

  assign tx_count = g_path[0].cnt;
  assign tx_rdata = g_path[0].dout;
  assign tx_ovr   = g_path[0].ovr;
  assign rx_count = g_path[1].cnt;
  assign rx_rdata = g_path[1].dout;
  assign rx_ovr   = g_path[1].ovr;

  assign tx_full  = (tx_count == cap);
  assign tx_empty = (tx_count == '0);
  assign tx_trig  = ((cap - tx_count) >= tx_lvl);
  assign rx_full  = (rx_count == cap);
  assign rx_empty = (rx_count == '0);
  assign rx_trig  = (rx_count >= rx_lvl);

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
  parameter int DEPTH = 32,
  parameter int W = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic          fifo_on,
  input logic          tx_push,
  input logic          tx_pop,
  input logic [CW-1:0] tx_count,
  input logic          tx_full,
  input logic          tx_ovr,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [W-1:0]  rx_rdata,
  input logic [CW-1:0] rx_count,
  input logic          rx_empty,
  input logic          rx_ovr
);

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  // R3
  hold_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |-> (tx_count <= CW'(1)) && (rx_count <= CW'(1)));

  // R7
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[1]) |=> (rx_count == '0) && !rx_ovr);

  // R7
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[2]) |=> (tx_count == '0) && !tx_ovr);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovr && !cfg_we) |=> tx_ovr);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && !tx_pop && !cfg_we) |=> tx_full && tx_ovr);

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && rx_pop && !rx_push && !cfg_we) |=> $stable(rx_rdata) && rx_empty);

  // R11
  full_pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && tx_pop && !cfg_we) |=> tx_full && $stable(tx_ovr));

endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH), .W(W)) u_chk (.*);

// File: tb/test_uart_fifo_pair.sv
`timescale 1ns/1ps
module test_uart_fifo_pair;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, xfeat_en;
  logic [7:0] cfg_wdata;
  logic       tx_push, tx_pop, rx_push, rx_pop;
  logic [7:0] tx_pdata, rx_pdata, tx_rdata, rx_rdata;
  logic [5:0] tx_count, rx_count;
  logic       tx_full, tx_empty, tx_trig, tx_ovr;
  logic       rx_full, rx_empty, rx_trig, rx_ovr;

  always #10 clk = ~clk;

  uart_fifo_pair i_uart_fifo_pair (.*);

  int nchk = 0, nbad = 0;
  int tn = 0, rn = 0;
  bit fon = 0, tov = 0, rov = 0;
  bit [1:0] tsel = 0, rsel = 0;
  bit want_tx = 0, want_rx = 0, mon_tx = 0, mon_rx = 0;
  byte unsigned tq[$], rq[$];
  byte unsigned last_rx = 0, seed = 8'h10;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog R1 act=0 exp=1");
    finish_run();
  end

  always @(posedge clk) begin
    mon_tx <= want_tx;
    mon_rx <= want_rx;
  end

  always @(negedge clk) begin
    byte unsigned e;
    if (mon_tx) begin
      e = tq.pop_front();
      chk("R2/R10 tx pop data", int'(tx_rdata), int'(e));
    end
    if (mon_rx) begin
      e = rq.pop_front();
      chk("R2/R10 rx pop data", int'(rx_rdata), int'(e));
      last_rx = e;
    end
  end

  function automatic int cap_f();
    return fon ? 32 : 1;
  endfunction

  function automatic int tlvl();
    if (!fon) return 1;
    if (!xfeat_en) return 16;
    case (tsel)
      2'd0: return 16;
      2'd1: return 8;
      2'd2: return 24;
      default: return 30;
    endcase
  endfunction

  function automatic int rlvl();
    if (!fon) return 1;
    case (rsel)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 24;
      default: return 28;
    endcase
  endfunction

  task automatic check_all(string tag);
    chk({tag, " tx_count"}, int'(tx_count), tn);
    chk({tag, " rx_count"}, int'(rx_count), rn);
    chk({tag, " tx_empty"}, int'(tx_empty), int'(tn == 0));
    chk({tag, " rx_empty"}, int'(rx_empty), int'(rn == 0));
    chk({tag, " tx_full"}, int'(tx_full), int'(tn == cap_f()));
    chk({tag, " rx_full"}, int'(rx_full), int'(rn == cap_f()));
    chk({tag, " tx_trig"}, int'(tx_trig), int'((cap_f() - tn) >= tlvl()));
    chk({tag, " rx_trig"}, int'(rx_trig), int'(rn >= rlvl()));
    chk({tag, " tx_ovr"}, int'(tx_ovr), int'(tov));
    chk({tag, " rx_ovr"}, int'(rx_ovr), int'(rov));
  endtask

  task automatic step(bit tp, byte unsigned td, bit tpo, bit rp, byte unsigned rd, bit rpo,
                      bit we, byte unsigned wd);
    bit fl, tcl, rcl, pok, uok;
    int cap;
    tx_push = tp; tx_pdata = td; tx_pop = tpo;
    rx_push = rp; rx_pdata = rd; rx_pop = rpo;
    cfg_we = we; cfg_wdata = wd;
    cap = cap_f();
    fl  = we && (wd[0] != fon);
    tcl = we && (wd[2] || fl);
    rcl = we && (wd[1] || fl);
    if (tcl) begin
      tn = 0; tq.delete(); tov = 0; want_tx = 0;
    end else begin
      pok = tpo && tn > 0;
      uok = tp && (tn < cap || pok);
      want_tx = pok;
      if (uok) tq.push_back(td);
      tn = tn + int'(uok) - int'(pok);
      if (tp && !uok) tov = 1;
    end
    if (rcl) begin
      rn = 0; rq.delete(); rov = 0; want_rx = 0;
    end else begin
      pok = rpo && rn > 0;
      uok = rp && (rn < cap || pok);
      want_rx = pok;
      if (uok) rq.push_back(rd);
      rn = rn + int'(uok) - int'(pok);
      if (rp && !uok) rov = 1;
    end
    if (we) begin
      fon = wd[0]; tsel = wd[5:4]; rsel = wd[7:6];
    end
    @(negedge clk); #1;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; cfg_we = 0;
    want_tx = 0; want_rx = 0;
  endtask

  task automatic tpush();
    seed++; step(1, seed, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rpush();
    seed++; step(0, 0, 0, 1, seed, 0, 0, 0);
  endtask
  task automatic tpop();  step(0, 0, 1, 0, 0, 0, 0, 0); endtask
  task automatic rpop();  step(0, 0, 0, 0, 0, 1, 0, 0); endtask
  task automatic wcfg(byte unsigned w); step(0, 0, 0, 0, 0, 0, 1, w); endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_wdata = 0; xfeat_en = 0;
    tx_push = 0; tx_pdata = 0; tx_pop = 0; rx_push = 0; rx_pdata = 0; rx_pop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;

    // R1 reset state
    check_all("R1");
    chk("R1 tx_rdata", int'(tx_rdata), 0);
    chk("R1 rx_rdata", int'(rx_rdata), 0);

    // R3 holding mode
    rpush(); check_all("R3 rx hold");
    rpush(); check_all("R8 rx hold overrun");
    rpop();  check_all("R10 rx hold pop");
    rpop();  check_all("R9 rx empty pop");
    chk("R9 rx_rdata kept", int'(rx_rdata), int'(last_rx));
    tpush(); check_all("R3 tx hold");
    wcfg(8'h01); check_all("R3 mode flip flush");

    // R4 receive levels
    for (int s = 0; s < 4; s++) begin
      wcfg(8'(s << 6) | 8'h03);
      for (int i = 0; i < rlvl() - 1; i++) rpush();
      check_all("R4 below level");
      rpush();
      check_all("R4 at level");
    end
    for (int i = 0; i < 4; i++) rpush();
    check_all("R2 rx full");
    rpush(); check_all("R8 rx overrun");
    for (int i = 0; i < 32; i++) rpop();
    check_all("R8 overrun sticky after drain");
    rpop();
    check_all("R9 rx empty pop");
    chk("R9 rx_rdata kept", int'(rx_rdata), int'(last_rx));

    // R5 transmit level gated
    wcfg(8'h31);
    for (int i = 0; i < 16; i++) tpush();
    check_all("R5 free 16");
    tpush();
    check_all("R5 free 15");

    // R6 stored selection becomes active on enable
    wcfg(8'h11);
    check_all("R6 stored not active");
    xfeat_en = 1;
    @(negedge clk); #1;
    check_all("R6 activated");
    for (int s = 0; s < 4; s++) begin
      wcfg(8'(s << 4) | 8'h05);
      for (int i = 0; i < 32 - tlvl(); i++) tpush();
      check_all("R6 at level");
      tpush();
      check_all("R6 below level");
    end

    // R7 independent, one-shot flush
    for (int i = 0; i < 5; i++) rpush();
    wcfg(8'h05);
    check_all("R7 tx flush only");
    tpush();
    check_all("R7 self-clearing");

    // R11 push and pop together
    for (int i = 0; i < 31; i++) tpush();
    check_all("R11 tx filled");
    seed++; step(1, seed, 1, 0, 0, 0, 0, 0);
    check_all("R11 full push+pop");
    wcfg(8'h03);
    seed++; step(0, 0, 0, 1, seed, 1, 0, 0);
    check_all("R11 empty push+pop");
    chk("R11 rx_rdata kept", int'(rx_rdata), int'(last_rx));

    // R12 flush beats push
    seed++; step(0, 0, 0, 1, seed, 0, 1, 8'h03);
    check_all("R12 flush with push");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule